// File: doc/BRIEF.md
# Serial Transmit Queue with Free-Space Interrupt

This block is the transmit-side staging buffer of a synchronous serial port. The CPU writes words into a small first-in first-out queue. The serializer takes them from the head, one pop per word. A transmit interrupt request tells the CPU when the queue has room again. A two-bit threshold input sets how much free space must exist before the request rises.

The request is a level, not a pulse. It stays high for as long as the free space meets the selected threshold, and it drops once enough words have been written. The block also drives three status flags:
- a busy flag that shows the queue still holds unsent words;
- a sticky flag that records a write refused because the queue was full;
- a registered copy of a companion receive queue's not-empty condition, computed from that queue's fill level.

Top module: `ssp_txq`

## Requirements
- R1: A synchronous active-high reset empties the queue. In the cycle after reset, tx_irq is 1, and tx_busy, wr_ovf and rx_has_data are all 0.
- R2: The queue holds DEPTH words and returns them in write order. Whenever the queue is not empty, rd_data shows the oldest stored word.
- R3: With free = DEPTH minus the stored word count, tx_irq is 1 exactly when free is at least need. The threshold code thr_sel sets need to (code+1)*DEPTH/4. For DEPTH=4 this gives: code 0 needs 1 free slot, code 1 needs 2, code 2 needs 3, and code 3 needs 4 (queue empty).
- R4: tx_irq, tx_busy and wr_ovf are registers. After any clock edge they reflect the word count that results from the push and pop applied at that edge, and the thr_sel value sampled at that edge.
- R5: tx_busy is 0 when the queue is empty and 1 when it holds at least one word.
- R6: A write to a full queue without a pop in the same cycle is dropped. The stored data and the count stay unchanged, and wr_ovf goes to 1 and stays at 1 until reset.
- R7: When a push and a pop occur in the same cycle on a non-empty queue, both are accepted. The count stays unchanged and the write order is kept. This also holds when the queue is full, and then wr_ovf is not set.
- R8: A pop on an empty queue is ignored and the count stays 0. If a push arrives in the same cycle, the queue ends with that one word.
- R9: rx_has_data is 1 in the cycle after rx_fill is non-zero, and 0 in the cycle after rx_fill is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | W | CPU write word |
| rd_en | input | 1 | Serializer pop strobe |
| rd_data | output | W | Oldest stored word |
| thr_sel | input | 2 | Free-space threshold code |
| rx_fill | input | RXW | Fill level of the companion receive queue |
| tx_irq | output | 1 | Transmit interrupt request level |
| tx_busy | output | 1 | Queue holds unsent words |
| wr_ovf | output | 1 | Sticky dropped-write flag |
| rx_has_data | output | 1 | Receive queue not empty |

## Verification
The bench builds the block with DEPTH=4, W=8 and RXW=3. At this size every pairing of the four threshold codes with the five possible fill levels can be swept directly. Every receive fill value can also be driven. The overflow point and the full-queue push-with-pop case are reached in a few writes. A long pseudo-random run of push and pop traffic is then checked word by word against an arithmetic model of the queue.

// File: rtl/ssp_txq_pkg.sv
package ssp_txq_pkg;

  typedef enum logic [1:0] {
    THR_ONE_FREE   = 2'd0,
    THR_TWO_FREE   = 2'd1,
    THR_THREE_FREE = 2'd2,
    THR_ALL_FREE   = 2'd3
  } thr_code_e;

  // Free slots required for the request, scaled to the queue depth.
  function automatic int unsigned slots_needed(input thr_code_e code,
                                               input int unsigned depth);
    int unsigned idx;
    idx = int'(code) + 1;
    return (idx * depth) / 4;
  endfunction

endpackage

// File: rtl/ssp_txq_store.sv
module ssp_txq_store #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count_q,
  output logic [CW-1:0] count_next,
  output logic          push_drop
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic          full, empty, pop_ok, push_ok;

  assign full    = (count_q == CW'(DEPTH));
  assign empty   = (count_q == '0);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign push_drop = push && !push_ok;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    count_next = count_q;
    if (push_ok && !pop_ok)
      count_next = count_q + CW'(1);
    else if (pop_ok && !push_ok)
      count_next = count_q - CW'(1);
  end

  // Storage array kept free of reset so it maps onto RAM resources.
  always_ff @(posedge clk) begin
    if (push_ok)
      mem[wp_q] <= din;
  end

  assign dout = mem[rp_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wp_q <= wrap_inc(wp_q);
      if (pop_ok)  rp_q <= wrap_inc(rp_q);
      count_q <= count_next;
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));

  a_r7_pushpop_hold: assert property (@(posedge clk) disable iff (rst)
    (push && pop && count_q != '0) |=> $stable(count_q));

  a_r8_pop_empty: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && count_q == '0) |=> (count_q == '0));

  a_r6_drop_keeps: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && count_q == CW'(DEPTH)) |=> (count_q == CW'(DEPTH)));

endmodule

// File: rtl/ssp_txq_flags.sv
module ssp_txq_flags
  import ssp_txq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count_next,
  input  logic [1:0]    thr_sel,
  output logic          irq_q,
  output logic          busy_q
);

  logic [CW-1:0] free_next;
  logic [CW-1:0] need;

  assign free_next = CW'(DEPTH) - count_next;
  assign need      = CW'(slots_needed(thr_code_e'(thr_sel), DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b1;   // empty queue meets every threshold
      busy_q <= 1'b0;
    end else begin
      irq_q  <= (free_next >= need);
      busy_q <= (count_next != '0);
    end
  end

endmodule

// File: rtl/ssp_rxq_flag.sv
module ssp_rxq_flag #(
  parameter int RXW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [RXW-1:0] rx_fill,
  output logic           ne_q
);

  always_ff @(posedge clk) begin
    if (rst) ne_q <= 1'b0;
    else     ne_q <= |rx_fill;
  end

endmodule

// File: rtl/ssp_txq.sv
module ssp_txq #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int RXW   = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [W-1:0]   wr_data,
  input  logic           rd_en,
  output logic [W-1:0]   rd_data,
  input  logic [1:0]     thr_sel,
  input  logic [RXW-1:0] rx_fill,
  output logic           tx_irq,
  output logic           tx_busy,
  output logic           wr_ovf,
  output logic           rx_has_data
);

  logic [CW-1:0] fill_q, fill_next;
  logic          drop;
  logic          ovf_q;

  ssp_txq_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .push(wr_en), .din(wr_data), .pop(rd_en), .dout(rd_data),
    .count_q(fill_q), .count_next(fill_next), .push_drop(drop)
  );

  ssp_txq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst),
    .count_next(fill_next), .thr_sel(thr_sel),
    .irq_q(tx_irq), .busy_q(tx_busy)
  );

  ssp_rxq_flag #(.RXW(RXW)) u_rx (
    .clk(clk), .rst(rst), .rx_fill(rx_fill), .ne_q(rx_has_data)
  );

  always_ff @(posedge clk) begin
    if (rst)       ovf_q <= 1'b0;
    else if (drop) ovf_q <= 1'b1;
  end
  assign wr_ovf = ovf_q;

  a_r3_full_quiet: assert property (@(posedge clk) disable iff (rst)
    (fill_q == CW'(DEPTH)) |-> !tx_irq);

  a_r3_empty_raises: assert property (@(posedge clk) disable iff (rst)
    (fill_q == '0) |-> tx_irq);

  a_r5_busy_tracks: assert property (@(posedge clk) disable iff (rst)
    tx_busy == (fill_q != '0));

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    wr_ovf |=> wr_ovf);

  a_r9_rx_follow: assert property (@(posedge clk) disable iff (rst)
    (rx_fill == '0) |=> !rx_has_data);

endmodule

// File: tb/ssp_txq_test.sv
`timescale 1ns/1ps
module ssp_txq_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [1:0] thr_sel = 2'd0;
  logic [2:0] rx_fill = '0;
  logic       tx_irq, tx_busy, wr_ovf, rx_has_data;

  int total = 0;
  int bad = 0;

  int        mcnt = 0;
  logic [7:0] mq [4];
  logic      movf = 1'b0;

  always #4 clk = ~clk;

  ssp_txq #(.W(8), .DEPTH(4), .RXW(3)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .thr_sel(thr_sel), .rx_fill(rx_fill),
    .tx_irq(tx_irq), .tx_busy(tx_busy), .wr_ovf(wr_ovf),
    .rx_has_data(rx_has_data)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic p, input logic [7:0] d, input logic q);
    bit pop_ok, push_ok;
    wr_en = p; wr_data = d; rd_en = q;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    pop_ok  = q && (mcnt > 0);
    push_ok = p && ((mcnt < 4) || pop_ok);
    if (pop_ok) begin
      for (int i = 0; i < 3; i++) mq[i] = mq[i+1];
      mcnt--;
    end
    if (push_ok) begin
      mq[mcnt] = d;
      mcnt++;
    end
    if (p && !push_ok) movf = 1'b1;
  endtask

  // R2 R3 R4 R5 R6 against the model
  task automatic verify();
    int need;
    need = int'(thr_sel) + 1;
    if (mcnt > 0) check("R2 head word", int'(rd_data), int'(mq[0]));
    check("R3 R4 irq level", int'(tx_irq), ((4 - mcnt) >= need) ? 1 : 0);
    check("R5 busy", int'(tx_busy), (mcnt != 0) ? 1 : 0);
    check("R6 ovf", int'(wr_ovf), int'(movf));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mcnt = 0; movf = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();
    // R1 reset state
    check("R1 irq", int'(tx_irq), 1);
    check("R1 busy", int'(tx_busy), 0);
    check("R1 ovf", int'(wr_ovf), 0);
    check("R1 rx", int'(rx_has_data), 0);

    // R3 R4 R5: every threshold code at every fill level
    for (int t = 0; t < 4; t++) begin
      do_reset();
      thr_sel = 2'(t);
      step(1'b0, 8'h00, 1'b0);
      for (int k = 0; k < 4; k++) begin
        verify();
        step(1'b1, 8'(16 * t + k + 1), 1'b0);
      end
      verify();
      // R6 dropped write at full
      step(1'b1, 8'hEE, 1'b0);
      verify();
      check("R6 sticky", int'(wr_ovf), 1);
      // R2 drain in order; R6 stays set
      for (int k = 0; k < 4; k++) begin
        check("R2 order", int'(rd_data), 16 * t + k + 1);
        step(1'b0, 8'h00, 1'b1);
        verify();
      end
      check("R6 held", int'(wr_ovf), 1);
    end

    // R4: threshold change takes effect after one edge
    do_reset();
    thr_sel = 2'd0;
    step(1'b1, 8'h51, 1'b0);
    step(1'b1, 8'h52, 1'b0);
    thr_sel = 2'd2;
    check("R4 before edge", int'(tx_irq), 1);
    step(1'b0, 8'h00, 1'b0);
    check("R4 after edge", int'(tx_irq), 0);

    // R7 push+pop at every non-empty fill, including full
    do_reset();
    thr_sel = 2'd1;
    for (int f = 1; f <= 4; f++) begin
      step(1'b1, 8'(8'h60 + f), 1'b0);
      verify();
      step(1'b1, 8'(8'h70 + f), 1'b1);
      verify();
      check("R7 count held", int'(tx_busy), 1);
    end
    check("R7 no ovf at full", int'(wr_ovf), 0);
    for (int k = 0; k < 4; k++) begin
      verify();
      step(1'b0, 8'h00, 1'b1);
    end
    verify();

    // R8 pop on empty, and pop with push on empty
    step(1'b0, 8'h00, 1'b1);
    check("R8 stays empty", int'(tx_busy), 0);
    verify();
    step(1'b1, 8'hA5, 1'b1);
    check("R8 one word", int'(rd_data), 8'hA5);
    verify();
    step(1'b0, 8'h00, 1'b1);
    check("R8 drained", int'(tx_busy), 0);

    // R9 every receive fill value
    for (int v = 0; v < 8; v++) begin
      rx_fill = 3'(v);
      step(1'b0, 8'h00, 1'b0);
      check("R9 rx flag", int'(rx_has_data), (v != 0) ? 1 : 0);
    end
    rx_fill = '0;
    step(1'b0, 8'h00, 1'b0);
    check("R9 rx clear", int'(rx_has_data), 0);

    // Mixed pseudo-random traffic, R2 R3 R6 R7 R8
    do_reset();
    lfsr = 16'hACE1;
    for (int n = 0; n < 2000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (n % 97 == 0) thr_sel = lfsr[9:8];
      step(lfsr[0] | lfsr[5], lfsr[15:8], lfsr[1] & lfsr[3]);
      verify();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule